// File: doc/BRIEF.md
# Interrupt Context Stack Sequencer

This block saves a processor's working context to a stack that lives in main memory, and reloads it later. When an interrupt is taken or a push-jump instruction runs, it captures the accumulator, program counter, multiplier-quotient register, status flags, machine level and field registers in one clock. It then writes them as five 12-bit words to consecutive locations starting at a programmable 15-bit stack pointer, and hands back the context the processor should continue with. A restore command reverses this. It reads the five words back in reverse order, unpacks them, and returns the saved context, with the stack pointer back where it stood before the matching push.

Every memory access is a break cycle. The block raises a break request for the whole sequence and makes one access in each cycle the break grant is high. The block has the lowest priority on the bus, so other masters may take any number of cycles between its accesses. A restore that arrives while the processor is not interruptible is held until it becomes interruptible. Priority selection, instruction decoding and the memory array sit outside the block.

Top module: `ctx_stack_seq`

## Requirements
- R1: A push writes five words at stack pointer P, P+1, P+2, P+3, P+4, in this order: accumulator, saved PC, status word, MQ, field word. The pointer then reads P+5.
- R2: The status word holds alt_mode in bit 0, flow in bit 1, link in bit 2 and the 4-bit machine level in bits 11:8. All other bits are 0.
- R3: The field word holds uf in bit 1, the 5-bit instruction field in bits 6:2 and the 5-bit data field in bits 11:7. Bit 0 is 0.
- R4: brk_req stays high from the start of a push or pop to its last access. An access (a write for a push, a read for a pop) happens only in a cycle where brk_grant is high. Exactly five accesses are made, and a cycle without grant leaves the pointer unchanged.
- R5: The stack pointer is one 15-bit counter. It carries from 0x0FFF to 0x1000 and wraps from 0x7FFF to 0x0000 in both directions. sp_load writes it while the block is idle.
- R6: An interrupt push returns out_pc = irq_vector[11:0] and out_ifld = irq_vector[14:12] zero-extended. It forces out_alt_mode to 0 and passes every other field through from the captured context. The saved PC is in_pc unchanged.
- R7: A push-jump saves in_pc+2 (modulo 4096) as the PC. It returns out_pc = pj_addr and out_ifld = pj_field zero-extended, and keeps the current alt_mode.
- R8: A pop reads P-1 down to P-5, one decrement before each read. It returns every saved field, the saved alt_mode included, and leaves the pointer at P-5.
- R9: A rest_req pulse is remembered. While interruptible is low no pop starts. The pop starts once the block is idle and interruptible is high.
- R10: The context is sampled in the cycle a push is accepted. Later input changes do not alter the stored words.
- R11: When several requests are present in an idle cycle, the interrupt push goes first, then the push-jump, then a pending restore. irq_push, pj_req and sp_load have no effect while brk_req is high.
- R12: out_valid pulses for exactly one cycle, in the cycle after the fifth access. After reset, brk_req, out_valid and mem_we are 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sp_load | input | 1 | Load the stack pointer (idle only) |
| sp_load_val | input | 15 | Value for sp_load |
| sp_value | output | 15 | Current stack pointer |
| irq_push | input | 1 | Take an interrupt: push and vector |
| irq_vector | input | 15 | Vector: field in 14:12, address in 11:0 |
| pj_req | input | 1 | Push-jump request |
| pj_field | input | 3 | Push-jump target field |
| pj_addr | input | 12 | Push-jump target address |
| rest_req | input | 1 | Restore request pulse |
| interruptible | input | 1 | Processor is in an interruptible state |
| brk_req | output | 1 | Break request, high during a sequence |
| brk_grant | input | 1 | Break grant for this cycle |
| mem_addr | output | 15 | Memory address of the current access |
| mem_wdata | output | 12 | Write data |
| mem_we | output | 1 | Write enable |
| mem_rdata | input | 12 | Read data, valid in the same cycle as mem_addr |
| in_ac | input | 12 | Live accumulator |
| in_pc | input | 12 | Live program counter |
| in_mq | input | 12 | Live MQ register |
| in_alt_mode | input | 1 | Live mode flag (1 = alternate mode) |
| in_flow | input | 1 | Live overflow flag |
| in_link | input | 1 | Live link bit |
| in_level | input | 4 | Live machine level |
| in_uf | input | 1 | Live user flag |
| in_ifld | input | 5 | Live instruction field |
| in_dfld | input | 5 | Live data field |
| out_valid | output | 1 | Result context valid (one cycle) |
| out_ac | output | 12 | Result accumulator |
| out_pc | output | 12 | Result program counter |
| out_mq | output | 12 | Result MQ |
| out_alt_mode | output | 1 | Result mode flag |
| out_flow | output | 1 | Result overflow flag |
| out_link | output | 1 | Result link bit |
| out_level | output | 4 | Result machine level |
| out_uf | output | 1 | Result user flag |
| out_ifld | output | 5 | Result instruction field |
| out_dfld | output | 5 | Result data field |

## Verification
An interrupt push and a pending restore can be ready in the same idle cycle. So can an interrupt push and a push-jump. The bench provokes both by raising irq_push in the same cycle as rest_req, and in another run in the same cycle as pj_req. The scoreboard then expects exactly one push frame, followed in the restore case by a pop that returns the context just saved. Any extra or reordered access shows up as a mismatch against the expected access queue. A second collision is a grant that is withheld while sp_load or irq_push arrives mid-sequence. There the bench checks that the final pointer and the access stream are untouched.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    localparam int WORD_W    = 12;
    localparam int ADDR_W    = 15;
    localparam int FIELD_W   = 3;
    localparam int LVL_W     = 4;
    localparam int XF_W      = 5;
    localparam int FRAME_LEN = 5;
    localparam int STEP_W    = $clog2(FRAME_LEN);
    localparam int LAST_SLOT = FRAME_LEN - 1;
    localparam int PJ_ADV    = 2;

    // slot order inside a frame: the pop reads the AC slot last
    localparam int SLOT_AC   = 0;
    localparam int SLOT_PC   = 1;
    localparam int SLOT_STAT = 2;
    localparam int SLOT_MQ   = 3;
    localparam int SLOT_FLD  = 4;

    localparam int STAT_MODE_BIT = 0;
    localparam int STAT_FLOW_BIT = 1;
    localparam int STAT_LINK_BIT = 2;
    localparam int STAT_LVL_LSB  = 8;
    localparam int FLD_UF_BIT    = 1;
    localparam int FLD_IF_LSB    = 2;
    localparam int FLD_DF_LSB    = 7;

    typedef logic [WORD_W-1:0]                 word_t;
    typedef logic [ADDR_W-1:0]                 addr_t;
    typedef logic [STEP_W-1:0]                 step_t;
    typedef logic [FRAME_LEN-1:0][WORD_W-1:0]  frame_t;

    typedef struct packed {
        logic [WORD_W-1:0] ac;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] mq;
        logic              alt_mode;
        logic              flow;
        logic              link;
        logic [LVL_W-1:0]  level;
        logic              uf;
        logic [XF_W-1:0]   ifld;
        logic [XF_W-1:0]   dfld;
    } ctx_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PUSH = 2'd1,
        SEQ_POP  = 2'd2,
        SEQ_DONE = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_IRQ  = 2'd1,
        OP_PJ   = 2'd2,
        OP_REST = 2'd3
    } op_e;

    function automatic word_t pack_status(input ctx_t c);
        word_t w;
        w = '0;
        w[STAT_MODE_BIT]              = c.alt_mode;
        w[STAT_FLOW_BIT]              = c.flow;
        w[STAT_LINK_BIT]              = c.link;
        w[STAT_LVL_LSB +: LVL_W]      = c.level;
        return w;
    endfunction

    function automatic word_t pack_fields(input ctx_t c);
        word_t w;
        w = '0;
        w[FLD_UF_BIT]                 = c.uf;
        w[FLD_IF_LSB +: XF_W]         = c.ifld;
        w[FLD_DF_LSB +: XF_W]         = c.dfld;
        return w;
    endfunction

    function automatic frame_t to_frame(input ctx_t c);
        frame_t f;
        f[SLOT_AC]   = c.ac;
        f[SLOT_PC]   = c.pc;
        f[SLOT_STAT] = pack_status(c);
        f[SLOT_MQ]   = c.mq;
        f[SLOT_FLD]  = pack_fields(c);
        return f;
    endfunction

    function automatic ctx_t from_frame(input frame_t f);
        ctx_t c;
        c.ac       = f[SLOT_AC];
        c.pc       = f[SLOT_PC];
        c.mq       = f[SLOT_MQ];
        c.alt_mode = f[SLOT_STAT][STAT_MODE_BIT];
        c.flow     = f[SLOT_STAT][STAT_FLOW_BIT];
        c.link     = f[SLOT_STAT][STAT_LINK_BIT];
        c.level    = f[SLOT_STAT][STAT_LVL_LSB +: LVL_W];
        c.uf       = f[SLOT_FLD][FLD_UF_BIT];
        c.ifld     = f[SLOT_FLD][FLD_IF_LSB +: XF_W];
        c.dfld     = f[SLOT_FLD][FLD_DF_LSB +: XF_W];
        return c;
    endfunction

endpackage

// File: rtl/ctx_sp_counter.sv
module ctx_sp_counter #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] sp
);

    // one flat counter: carries ripple across the field boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (load) begin
            sp <= load_val;
        end else if (inc) begin
            sp <= sp + 1'b1;
        end else if (dec) begin
            sp <= sp - 1'b1;
        end
    end

    // R5: the control never asks for both directions at once
    a_r5_single_direction: assert property (@(posedge clk) disable iff (rst)
        !(inc && dec));

    // R5: increment from all-ones wraps to zero
    a_r5_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && (sp == {W{1'b1}})) |=> (sp == '0));

    // R5: decrement from zero wraps to all-ones
    a_r5_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && !load && (sp == '0)) |=> (sp == {W{1'b1}}));

endmodule

// File: rtl/ctx_word_sel.sv
module ctx_word_sel
    import ctx_pkg::*;
(
    input  frame_t frame,
    input  step_t  step,
    output word_t  word
);

    logic [FRAME_LEN-1:0] hit;

    for (genvar g = 0; g < FRAME_LEN; g++) begin : g_slot
        assign hit[g] = (step == STEP_W'(g));
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < FRAME_LEN; i++) begin
            word = word | (frame[i] & {WORD_W{hit[i]}});
        end
    end

endmodule

// File: rtl/ctx_seq_ctrl.sv
module ctx_seq_ctrl
    import ctx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       irq_push,
    input  logic       pj_req,
    input  logic       rest_pending,
    input  logic       interruptible,
    input  logic       brk_grant,
    output seq_state_e state,
    output step_t      step,
    output op_e        start_op,
    output logic       access,
    output logic       last_access
);

    localparam step_t LAST_STEP = step_t'(LAST_SLOT);

    // arbitration among requests, only evaluated while idle
    always_comb begin
        start_op = OP_NONE;
        if (state == SEQ_IDLE) begin
            if (irq_push) begin
                start_op = OP_IRQ;
            end else if (pj_req) begin
                start_op = OP_PJ;
            end else if (rest_pending && interruptible) begin
                start_op = OP_REST;
            end
        end
    end

    assign access      = ((state == SEQ_PUSH) || (state == SEQ_POP)) && brk_grant;
    assign last_access = access && (step == LAST_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            step  <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    step <= '0;
                    if ((start_op == OP_IRQ) || (start_op == OP_PJ)) begin
                        state <= SEQ_PUSH;
                    end else if (start_op == OP_REST) begin
                        state <= SEQ_POP;
                    end
                end
                SEQ_PUSH, SEQ_POP: begin
                    if (access) begin
                        if (step == LAST_STEP) begin
                            state <= SEQ_DONE;
                            step  <= '0;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end
                end
                SEQ_DONE: begin
                    state <= SEQ_IDLE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R9: no pop may begin while the processor is not interruptible
    a_r9_hold_restore: assert property (@(posedge clk) disable iff (rst)
        ((state == SEQ_IDLE) && !interruptible) |=> (state != SEQ_POP));

    // R11: an interrupt request in an idle cycle always starts a push
    a_r11_irq_first: assert property (@(posedge clk) disable iff (rst)
        ((state == SEQ_IDLE) && irq_push) |=> (state == SEQ_PUSH));

    // R11: a request arriving mid-sequence does not restart it
    a_r11_no_restart: assert property (@(posedge clk) disable iff (rst)
        ((state == SEQ_PUSH) && !brk_grant) |=> (state == SEQ_PUSH) && $stable(step));

    // R12: the completion state lasts one cycle
    a_r12_done_once: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_DONE) |=> (state == SEQ_IDLE));

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
    import ctx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sp_load,
    input  logic [14:0] sp_load_val,
    output logic [14:0] sp_value,
    input  logic        irq_push,
    input  logic [14:0] irq_vector,
    input  logic        pj_req,
    input  logic [2:0]  pj_field,
    input  logic [11:0] pj_addr,
    input  logic        rest_req,
    input  logic        interruptible,
    output logic        brk_req,
    input  logic        brk_grant,
    output logic [14:0] mem_addr,
    output logic [11:0] mem_wdata,
    output logic        mem_we,
    input  logic [11:0] mem_rdata,
    input  logic [11:0] in_ac,
    input  logic [11:0] in_pc,
    input  logic [11:0] in_mq,
    input  logic        in_alt_mode,
    input  logic        in_flow,
    input  logic        in_link,
    input  logic [3:0]  in_level,
    input  logic        in_uf,
    input  logic [4:0]  in_ifld,
    input  logic [4:0]  in_dfld,
    output logic        out_valid,
    output logic [11:0] out_ac,
    output logic [11:0] out_pc,
    output logic [11:0] out_mq,
    output logic        out_alt_mode,
    output logic        out_flow,
    output logic        out_link,
    output logic [3:0]  out_level,
    output logic        out_uf,
    output logic [4:0]  out_ifld,
    output logic [4:0]  out_dfld
);

    localparam step_t LAST_STEP = step_t'(LAST_SLOT);
    localparam int    OFF_W     = ADDR_W - FIELD_W;

    seq_state_e state;
    step_t      step;
    op_e        start_op;
    logic       access;
    logic       last_access;
    logic       busy;
    logic       rest_pending;

    addr_t      sp;
    ctx_t       live_ctx;
    ctx_t       cap_ctx;
    ctx_t       push_res;
    ctx_t       res_ctx;
    frame_t     push_frame;
    frame_t     rbuf;
    frame_t     rd_frame;
    word_t      push_word;
    step_t      rd_slot;

    logic [OFF_W-1:0]   tgt_pc;
    logic [FIELD_W-1:0] tgt_field;
    logic               tgt_irq;

    ctx_seq_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .irq_push      (irq_push),
        .pj_req        (pj_req),
        .rest_pending  (rest_pending),
        .interruptible (interruptible),
        .brk_grant     (brk_grant),
        .state         (state),
        .step          (step),
        .start_op      (start_op),
        .access        (access),
        .last_access   (last_access)
    );

    assign busy = (state == SEQ_PUSH) || (state == SEQ_POP);

    ctx_sp_counter #(.W(ADDR_W)) u_sp (
        .clk      (clk),
        .rst      (rst),
        .load     (sp_load && !busy),
        .load_val (sp_load_val),
        .inc      (access && (state == SEQ_PUSH)),
        .dec      (access && (state == SEQ_POP)),
        .sp       (sp)
    );

    // live context as seen on the inputs this cycle
    always_comb begin
        live_ctx.ac       = in_ac;
        live_ctx.pc       = in_pc;
        live_ctx.mq       = in_mq;
        live_ctx.alt_mode = in_alt_mode;
        live_ctx.flow     = in_flow;
        live_ctx.link     = in_link;
        live_ctx.level    = in_level;
        live_ctx.uf       = in_uf;
        live_ctx.ifld     = in_ifld;
        live_ctx.dfld     = in_dfld;
    end

    // a restore request is remembered until a pop is launched
    always_ff @(posedge clk) begin
        if (rst) begin
            rest_pending <= 1'b0;
        end else begin
            rest_pending <= rest_req || (rest_pending && (start_op != OP_REST));
        end
    end

    // snapshot of the context and jump target at push acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_ctx   <= '0;
            tgt_pc    <= '0;
            tgt_field <= '0;
            tgt_irq   <= 1'b0;
        end else if (start_op == OP_IRQ) begin
            cap_ctx   <= live_ctx;
            tgt_pc    <= irq_vector[OFF_W-1:0];
            tgt_field <= irq_vector[ADDR_W-1:OFF_W];
            tgt_irq   <= 1'b1;
        end else if (start_op == OP_PJ) begin
            cap_ctx    <= live_ctx;
            cap_ctx.pc <= in_pc + WORD_W'(PJ_ADV);
            tgt_pc     <= pj_addr;
            tgt_field  <= pj_field;
            tgt_irq    <= 1'b0;
        end
    end

    // write side: frame of the snapshot, one word per granted cycle
    assign push_frame = to_frame(cap_ctx);

    ctx_word_sel u_wsel (
        .frame (push_frame),
        .step  (step),
        .word  (push_word)
    );

    // read side: a pop walks the slots from the top of the frame down
    assign rd_slot = LAST_STEP - step;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbuf <= '0;
        end else if (access && (state == SEQ_POP)) begin
            rbuf[rd_slot] <= mem_rdata;
        end
    end

    always_comb begin
        rd_frame          = rbuf;
        rd_frame[SLOT_AC] = mem_rdata;
    end

    always_comb begin
        push_res          = cap_ctx;
        push_res.pc       = tgt_pc;
        push_res.ifld     = XF_W'(tgt_field);
        push_res.alt_mode = tgt_irq ? 1'b0 : cap_ctx.alt_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_ctx <= '0;
        end else if (last_access) begin
            res_ctx <= (state == SEQ_POP) ? from_frame(rd_frame) : push_res;
        end
    end

    // memory side
    assign brk_req   = busy;
    assign mem_we    = access && (state == SEQ_PUSH);
    assign mem_addr  = (state == SEQ_POP) ? (sp - 1'b1) : sp;
    assign mem_wdata = push_word;
    assign sp_value  = sp;

    // result side
    assign out_valid    = (state == SEQ_DONE);
    assign out_ac       = res_ctx.ac;
    assign out_pc       = res_ctx.pc;
    assign out_mq       = res_ctx.mq;
    assign out_alt_mode = res_ctx.alt_mode;
    assign out_flow     = res_ctx.flow;
    assign out_link     = res_ctx.link;
    assign out_level    = res_ctx.level;
    assign out_uf       = res_ctx.uf;
    assign out_ifld     = res_ctx.ifld;
    assign out_dfld     = res_ctx.dfld;

    // R1: each granted push cycle advances the pointer by one
    a_r1_push_advance: assert property (@(posedge clk) disable iff (rst)
        (mem_we) |=> (sp_value == $past(sp_value) + 15'd1));

    // R8: each granted pop cycle retreats the pointer by one
    a_r8_pop_retreat: assert property (@(posedge clk) disable iff (rst)
        (brk_req && brk_grant && !mem_we) |=> (sp_value == $past(sp_value) - 15'd1));

    // R4: a withheld grant freezes the pointer
    a_r4_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (brk_req && !brk_grant) |=> $stable(sp_value));

    // R11: a load during a sequence is dropped
    a_r11_load_blocked: assert property (@(posedge clk) disable iff (rst)
        (brk_req && sp_load && !brk_grant) |=> $stable(sp_value));

    // R12: completion follows a granted access
    a_r12_valid_after_grant: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(brk_grant && brk_req));

    // R12: single-cycle completion strobe
    a_r12_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

endmodule

// File: tb/ctx_stack_seq_test.sv
module ctx_stack_seq_test;

    typedef struct packed {
        logic [11:0] ac;
        logic [11:0] pc;
        logic [11:0] mq;
        logic        mode;
        logic        flow;
        logic        link;
        logic [3:0]  lvl;
        logic        uf;
        logic [4:0]  fi;
        logic [4:0]  fd;
    } bctx_t;

    typedef struct packed {
        logic        we;
        logic [14:0] addr;
        logic [11:0] data;
        logic [7:0]  tag;
    } acc_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic        sp_load = 1'b0;
    logic [14:0] sp_load_val = '0;
    logic [14:0] sp_value;
    logic        irq_push = 1'b0;
    logic [14:0] irq_vector = '0;
    logic        pj_req = 1'b0;
    logic [2:0]  pj_field = '0;
    logic [11:0] pj_addr = '0;
    logic        rest_req = 1'b0;
    logic        interruptible = 1'b0;
    logic        brk_req;
    logic        brk_grant;
    logic [14:0] mem_addr;
    logic [11:0] mem_wdata;
    logic        mem_we;
    logic [11:0] mem_rdata;
    logic        out_valid;
    logic [11:0] out_ac, out_pc, out_mq;
    logic        out_alt_mode, out_flow, out_link, out_uf;
    logic [3:0]  out_level;
    logic [4:0]  out_ifld, out_dfld;

    bctx_t cur = '0;

    ctx_stack_seq uut (
        .clk(clk), .rst(rst),
        .sp_load(sp_load), .sp_load_val(sp_load_val), .sp_value(sp_value),
        .irq_push(irq_push), .irq_vector(irq_vector),
        .pj_req(pj_req), .pj_field(pj_field), .pj_addr(pj_addr),
        .rest_req(rest_req), .interruptible(interruptible),
        .brk_req(brk_req), .brk_grant(brk_grant),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .in_ac(cur.ac), .in_pc(cur.pc), .in_mq(cur.mq), .in_alt_mode(cur.mode),
        .in_flow(cur.flow), .in_link(cur.link), .in_level(cur.lvl), .in_uf(cur.uf),
        .in_ifld(cur.fi), .in_dfld(cur.fd),
        .out_valid(out_valid), .out_ac(out_ac), .out_pc(out_pc), .out_mq(out_mq),
        .out_alt_mode(out_alt_mode), .out_flow(out_flow), .out_link(out_link),
        .out_level(out_level), .out_uf(out_uf), .out_ifld(out_ifld), .out_dfld(out_dfld)
    );

    // small memory model, indexed by the low address bits
    logic [11:0] bmem [0:63];
    always @(posedge clk) if (mem_we) bmem[mem_addr[5:0]] <= mem_wdata;
    assign mem_rdata = bmem[mem_addr[5:0]];

    // grant generator: full grant or periodic cycle stealing
    logic       steal = 1'b0;
    logic [1:0] gcnt = '0;
    always @(negedge clk) gcnt <= gcnt + 2'd1;
    assign brk_grant = !steal || (gcnt != 2'd1);

    int n_checks = 0;
    int n_fail = 0;
    logic [14:0] sp_model = '0;
    acc_t  acc_q[$];
    bctx_t res_q[$];
    int    rtag_q[$];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    function automatic logic [11:0] b_stat(input bctx_t c);
        return {c.lvl, 5'b00000, c.link, c.flow, c.mode};   // R2 layout
    endfunction

    function automatic logic [11:0] b_flds(input bctx_t c);
        return {c.fd, c.fi, c.uf, 1'b0};                       // R3 layout
    endfunction

    // monitor: compares every access and every result against the queues
    always @(negedge clk) begin
        #1;
        if (!rst && brk_req && brk_grant) begin
            if (acc_q.size() == 0) begin
                check(1'b0, "R11 unexpected access", {49'd0, mem_addr}, 64'd0);
            end else begin
                acc_t e;
                e = acc_q.pop_front();
                check(mem_we == e.we, $sformatf("R%0d access kind", e.tag), {63'd0, mem_we}, {63'd0, e.we});
                check(mem_addr == e.addr, $sformatf("R%0d address", e.tag), {49'd0, mem_addr}, {49'd0, e.addr});
                if (e.we)
                    check(mem_wdata == e.data, $sformatf("R%0d write data", e.tag), {52'd0, mem_wdata}, {52'd0, e.data});
            end
        end
        if (!rst && brk_req && !brk_grant)
            check(!mem_we, "R4 write without grant", {63'd0, mem_we}, 64'd0);
        if (!rst && out_valid) begin
            bctx_t a;
            a = {out_ac, out_pc, out_mq, out_alt_mode, out_flow, out_link, out_level, out_uf, out_ifld, out_dfld};
            if (res_q.size() == 0) begin
                check(1'b0, "R12 unexpected result", {1'b0, a}, 64'd0);
            end else begin
                bctx_t e;
                int t;
                e = res_q.pop_front();
                t = rtag_q.pop_front();
                check(a == e, $sformatf("R%0d result context", t), {1'b0, a}, {1'b0, e});
            end
        end
    end

    task automatic load_sp(input logic [14:0] v);
        @(negedge clk);
        sp_load = 1'b1;
        sp_load_val = v;
        @(negedge clk);
        sp_load = 1'b0;
        sp_model = v;
    endtask

    task automatic expect_pop(input bctx_t saved, input int tag);
        for (int i = 1; i <= 5; i++)
            acc_q.push_back('{we: 1'b0, addr: sp_model - 15'(i), data: 12'd0, tag: 8'(tag)});
        sp_model = sp_model - 15'd5;
        res_q.push_back(saved);
        rtag_q.push_back(tag);
    endtask

    // driver: queues the expected frame and result, then raises the request
    task automatic do_push(input bit is_pj, input logic [14:0] vec, input logic [2:0] pf,
                           input logic [11:0] pa, input int tag, input bit with_pj,
                           input bit with_rest, output bctx_t saved);
        bctx_t r;
        logic [11:0] w [5];
        saved = cur;
        if (is_pj) saved.pc = cur.pc + 12'd2;                  // R7
        w[0] = saved.ac; w[1] = saved.pc; w[2] = b_stat(saved);
        w[3] = saved.mq; w[4] = b_flds(saved);
        for (int i = 0; i < 5; i++) begin
            int t;
            t = (i == 2) ? 2 : (i == 4) ? 3 : tag;
            acc_q.push_back('{we: 1'b1, addr: sp_model + 15'(i), data: w[i], tag: 8'(t)});
        end
        sp_model = sp_model + 15'd5;
        r = saved;
        if (is_pj) begin
            r.pc = pa;
            r.fi = {2'b00, pf};
        end else begin
            r.pc = vec[11:0];                                   // R6
            r.fi = {2'b00, vec[14:12]};
            r.mode = 1'b0;
        end
        res_q.push_back(r);
        rtag_q.push_back(is_pj ? 7 : 6);
        if (with_rest) expect_pop(saved, 11);
        @(negedge clk);
        irq_vector = vec;
        pj_field = pf;
        pj_addr = pa;
        irq_push = !is_pj;
        pj_req = is_pj || with_pj;
        rest_req = with_rest;
        @(negedge clk);
        irq_push = 1'b0;
        pj_req = 1'b0;
        rest_req = 1'b0;
        cur = ~cur;                                             // R10: scramble after capture
    endtask

    task automatic pulse_rest;
        @(negedge clk);
        rest_req = 1'b1;
        @(negedge clk);
        rest_req = 1'b0;
    endtask

    task automatic wait_idle;
        while (acc_q.size() != 0 || res_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        finish_up;
    end

    initial begin
        bctx_t sa, sb, sc, sd, se;
        repeat (3) @(negedge clk);
        #1;
        // R12: reset state
        check(brk_req == 1'b0, "R12 reset brk_req", {63'd0, brk_req}, 64'd0);
        check(out_valid == 1'b0, "R12 reset out_valid", {63'd0, out_valid}, 64'd0);
        check(mem_we == 1'b0, "R12 reset mem_we", {63'd0, mem_we}, 64'd0);
        check(sp_value == 15'd0, "R12 reset pointer", {49'd0, sp_value}, 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R5: pointer load
        load_sp(15'h0100);
        #1;
        check(sp_value == 15'h0100, "R5 pointer load", {49'd0, sp_value}, 64'h100);

        // R1 R6: interrupt push with full grant
        cur = '{ac: 12'h123, pc: 12'h456, mq: 12'h789, mode: 1'b1, flow: 1'b1, link: 1'b0,
                lvl: 4'h5, uf: 1'b1, fi: 5'h13, fd: 5'h0A};
        do_push(1'b0, 15'h3456, 3'd0, 12'd0, 1, 1'b0, 1'b0, sa);
        wait_idle;
        check(sp_value == 15'h0105, "R1 pointer after push", {49'd0, sp_value}, 64'h105);

        // R7 R10 R4: push-jump with stolen cycles and PC wrap
        steal = 1'b1;
        cur = '{ac: 12'hABC, pc: 12'hFFF, mq: 12'h001, mode: 1'b1, flow: 1'b0, link: 1'b1,
                lvl: 4'hF, uf: 1'b0, fi: 5'h1F, fd: 5'h11};
        do_push(1'b1, 15'd0, 3'd5, 12'h200, 10, 1'b0, 1'b0, sb);
        wait_idle;
        check(sp_value == 15'h010A, "R4 pointer after stolen push", {49'd0, sp_value}, 64'h10A);

        // R8: pop with grant stealing
        interruptible = 1'b1;
        expect_pop(sb, 8);
        pulse_rest;
        wait_idle;
        check(sp_value == 15'h0105, "R8 pointer after pop", {49'd0, sp_value}, 64'h105);

        // R9: restore held while not interruptible
        interruptible = 1'b0;
        pulse_rest;
        repeat (12) @(negedge clk);
        #1;
        check(brk_req == 1'b0, "R9 restore held", {63'd0, brk_req}, 64'd0);
        check(sp_value == 15'h0105, "R9 pointer untouched", {49'd0, sp_value}, 64'h105);
        expect_pop(sa, 9);
        interruptible = 1'b1;
        wait_idle;
        check(sp_value == 15'h0100, "R8 pointer back to origin", {49'd0, sp_value}, 64'h100);

        // R5: carry across the field boundary and full wrap
        steal = 1'b0;
        load_sp(15'h0FFE);
        cur = '{ac: 12'h0F0, pc: 12'h00E, mq: 12'h5A5, mode: 1'b0, flow: 1'b1, link: 1'b1,
                lvl: 4'h0, uf: 1'b1, fi: 5'h01, fd: 5'h1E};
        do_push(1'b0, 15'h7FFE, 3'd0, 12'd0, 5, 1'b0, 1'b0, sc);
        wait_idle;
        check(sp_value == 15'h1003, "R5 field carry", {49'd0, sp_value}, 64'h1003);
        load_sp(15'h7FFE);
        cur = '{ac: 12'h321, pc: 12'h654, mq: 12'h987, mode: 1'b1, flow: 1'b0, link: 1'b0,
                lvl: 4'hA, uf: 1'b0, fi: 5'h0C, fd: 5'h03};
        do_push(1'b0, 15'h1234, 3'd0, 12'd0, 5, 1'b0, 1'b0, sd);
        wait_idle;
        check(sp_value == 15'h0003, "R5 wrap up", {49'd0, sp_value}, 64'h3);
        expect_pop(sd, 5);
        pulse_rest;
        wait_idle;
        check(sp_value == 15'h7FFE, "R5 wrap down", {49'd0, sp_value}, 64'h7FFE);

        // R11: irq and push-jump in one cycle, then irq with restore in one cycle
        load_sp(15'h0200);
        cur = '{ac: 12'h111, pc: 12'h222, mq: 12'h333, mode: 1'b1, flow: 1'b1, link: 1'b1,
                lvl: 4'h3, uf: 1'b1, fi: 5'h04, fd: 5'h05};
        do_push(1'b0, 15'h2100, 3'd7, 12'h777, 11, 1'b1, 1'b0, se);
        wait_idle;
        check(sp_value == 15'h0205, "R11 only one push taken", {49'd0, sp_value}, 64'h205);
        cur = '{ac: 12'h444, pc: 12'h555, mq: 12'h666, mode: 1'b1, flow: 1'b0, link: 1'b1,
                lvl: 4'h9, uf: 1'b0, fi: 5'h10, fd: 5'h08};
        do_push(1'b0, 15'h5010, 3'd0, 12'd0, 11, 1'b0, 1'b1, se);
        wait_idle;
        check(sp_value == 15'h0205, "R11 push then restore", {49'd0, sp_value}, 64'h205);

        // R11: load and interrupt ignored mid-sequence
        steal = 1'b1;
        cur = '{ac: 12'h0AA, pc: 12'h0BB, mq: 12'h0CC, mode: 1'b0, flow: 1'b0, link: 1'b0,
                lvl: 4'h7, uf: 1'b1, fi: 5'h15, fd: 5'h0F};
        do_push(1'b0, 15'h0400, 3'd0, 12'd0, 11, 1'b0, 1'b0, se);
        @(negedge clk);
        sp_load = 1'b1;
        sp_load_val = 15'h7777;
        irq_push = 1'b1;
        @(negedge clk);
        sp_load = 1'b0;
        irq_push = 1'b0;
        wait_idle;
        check(sp_value == 15'h020A, "R11 load ignored while busy", {49'd0, sp_value}, 64'h20A);
        check(acc_q.size() == 0, "R11 no extra accesses", 64'(acc_q.size()), 64'd0);

        finish_up;
    end

endmodule